// File: doc/BRIEF.md
# Control Transfer Stage Sequencer

This block follows a control transfer on the default endpoint after a SETUP token arrives. It holds the current stage of the transfer (idle, setup, data or status) and the transfer direction taken from the request. For every IN or OUT token on the endpoint, it chooses the handshake that the packet engine returns: ACK, NAK or STALL.

Firmware controls the transfer with three command strobes. The arm command opens the data stage. The status command moves the transfer into the status stage, and it can skip the data stage when there is none. The stall command refuses the transfer. Until firmware arms the data stage, every data token is refused with NAK. The arm flag clears by itself when a data packet's handshake completes. Firmware cannot read the arm flag back. A new SETUP token ends whatever transfer was in progress.

Top module: `ctl_stage_seq`

## Requirements
- R1: After reset, `stage` is 0 (idle) and `resp_vld` is low.
- R2: A SETUP token has these effects:
  - `stage` becomes 1 (setup).
  - The token is answered with ACK.
  - The arm flag and any pending stall are cleared.
  - `setup_dir_in` is latched as the transfer direction (1 = IN, 0 = OUT).
  - The SETUP token takes priority over every other input in the same cycle.
- R3: In the setup stage, with no stall pending, IN and OUT tokens are answered with NAK.
- R4: `fw_dsen` in the setup stage moves `stage` to 2 (data). While armed and with no stall pending, a token in the transfer direction is then answered with ACK.
- R5: `hs_done` clears the arm flag. After that, data-direction tokens are answered with NAK until firmware arms the stage again.
- R6: `fw_status` in the setup or data stage moves `stage` to 3 (status) and clears the arm flag. In other stages it has no effect.
- R7: In the status stage, with no stall pending:
  - A token opposite to the transfer direction is answered with ACK, and `stage` returns to 0.
  - A token in the transfer direction is answered with NAK, and the stage is kept.
- R8: After `fw_stall`, every IN or OUT token is answered with STALL, in any stage, until the next SETUP token.
- R9: The readback of the arm command, `dsen_rdata`, always reads 0.
- R10: The response is registered. `resp_vld` and `resp` appear in the cycle after a token and are held for one cycle. The response codes are 0 none, 1 ACK, 2 NAK and 3 STALL.
- R11: In the idle stage, and in the data stage for a token opposite to the transfer direction, the response is NAK when no stall is pending.
- R12: Writing `fw_dsen` again while already in the data stage re-arms it. The next data-direction token is answered with ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_setup | input | 1 | SETUP token received (one-cycle pulse) |
| setup_dir_in | input | 1 | Direction of the request carried with the SETUP token; 1 = IN |
| tok_in | input | 1 | IN token on the endpoint |
| tok_out | input | 1 | OUT token on the endpoint |
| hs_done | input | 1 | A data packet's handshake has completed |
| fw_dsen | input | 1 | Firmware arm strobe for the data stage |
| fw_status | input | 1 | Firmware strobe to enter the status stage |
| fw_stall | input | 1 | Firmware stall strobe |
| stage | output | 2 | Current stage: 0 idle, 1 setup, 2 data, 3 status |
| resp | output | 2 | Handshake code: 0 none, 1 ACK, 2 NAK, 3 STALL |
| resp_vld | output | 1 | `resp` is valid this cycle |
| dsen_rdata | output | 1 | Readback of the arm command, always 0 |

## Verification
The hardest case to reach from the ports is a data stage that has been armed and then disarmed by a handshake. In that state, the same token that was acknowledged one packet earlier must now be refused. Reaching it takes a SETUP token, an arm command, a handshake and a token, in that order. The stall flag and the status-stage exit rule also interact with that path. The bench reaches all of these states with a sweep over every sequence of three commands or tokens that follows a SETUP token, for both transfer directions. Each step is compared against an arithmetic model kept inside the bench.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_SETUP  = 2'd1,
    STG_DATA   = 2'd2,
    STG_STATUS = 2'd3
  } stage_t;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_t;

  // Handshake for a data-phase token (IN when tok_is_in, else OUT).
  function automatic hs_t pick_hs(stage_t s, logic stall, logic arm,
                                  logic dir_in, logic tok_is_in);
    hs_t h;
    if (stall) h = HS_STALL;
    else begin
      case (s)
        STG_DATA:   h = (arm && (tok_is_in == dir_in)) ? HS_ACK : HS_NAK;
        STG_STATUS: h = (tok_is_in != dir_in) ? HS_ACK : HS_NAK;
        default:    h = HS_NAK;
      endcase
    end
    return h;
  endfunction

  function automatic logic stage_open(stage_t s);
    return (s == STG_SETUP) || (s == STG_DATA);
  endfunction
endpackage

// File: rtl/ctl_seq_flags.sv
module ctl_seq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_setup,
  input  logic fw_dsen,
  input  logic fw_stall,
  input  logic arm_clear,
  output logic arm_q,
  output logic stall_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      stall_q <= 1'b0;
    end else if (ev_setup) begin
      arm_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      if (fw_dsen)        arm_q <= 1'b1;
      else if (arm_clear) arm_q <= 1'b0;
      if (fw_stall)       stall_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ctl_seq_stage.sv
module ctl_seq_stage
  import ctl_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_setup,
  input  logic   setup_dir_in,
  input  logic   fw_dsen,
  input  logic   fw_status,
  input  logic   ev_status_ack,
  output stage_t stage_q,
  output logic   dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= STG_IDLE;
      dir_q   <= 1'b0;
    end else if (ev_setup) begin
      stage_q <= STG_SETUP;
      dir_q   <= setup_dir_in;
    end else if (ev_status_ack) begin
      stage_q <= STG_IDLE;
    end else if (fw_status && stage_open(stage_q)) begin
      stage_q <= STG_STATUS;
    end else if (fw_dsen && stage_q == STG_SETUP) begin
      stage_q <= STG_DATA;
    end
  end
endmodule

// File: rtl/ctl_seq_resp.sv
module ctl_seq_resp
  import ctl_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tok_setup,
  input  logic   tok_in,
  input  logic   tok_out,
  input  stage_t stage_q,
  input  logic   stall_q,
  input  logic   arm_q,
  input  logic   dir_q,
  output logic   ev_status_ack,
  output hs_t    resp_q,
  output logic   resp_vld_q
);
  logic tok_data;
  hs_t  hs_now;

  assign tok_data      = (tok_in || tok_out) && !tok_setup;
  assign hs_now        = pick_hs(stage_q, stall_q, arm_q, dir_q, tok_in);
  assign ev_status_ack = tok_data && (stage_q == STG_STATUS) && (hs_now == HS_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_q     <= HS_NONE;
      resp_vld_q <= 1'b0;
    end else begin
      resp_vld_q <= tok_setup || tok_data;
      if (tok_setup)     resp_q <= HS_ACK;
      else if (tok_data) resp_q <= hs_now;
      else               resp_q <= HS_NONE;
    end
  end
endmodule

// File: rtl/ctl_stage_seq.sv
module ctl_stage_seq
  import ctl_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_setup,
  input  logic       setup_dir_in,
  input  logic       tok_in,
  input  logic       tok_out,
  input  logic       hs_done,
  input  logic       fw_dsen,
  input  logic       fw_status,
  input  logic       fw_stall,
  output logic [1:0] stage,
  output logic [1:0] resp,
  output logic       resp_vld,
  output logic       dsen_rdata
);
  stage_t stage_q;
  hs_t    resp_q;
  logic   arm_q, stall_q, dir_q;
  logic   ev_setup, ev_status_ack, ev_enter_status, arm_clear;

  assign ev_setup        = tok_setup;
  assign ev_enter_status = fw_status && stage_open(stage_q);
  assign arm_clear       = hs_done || ev_enter_status;

  ctl_seq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev_setup(ev_setup), .fw_dsen(fw_dsen),
    .fw_stall(fw_stall), .arm_clear(arm_clear), .arm_q(arm_q), .stall_q(stall_q)
  );

  ctl_seq_stage u_stage (
    .clk(clk), .rst_n(rst_n), .ev_setup(ev_setup), .setup_dir_in(setup_dir_in),
    .fw_dsen(fw_dsen), .fw_status(fw_status), .ev_status_ack(ev_status_ack),
    .stage_q(stage_q), .dir_q(dir_q)
  );

  ctl_seq_resp u_resp (
    .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_in(tok_in),
    .tok_out(tok_out), .stage_q(stage_q), .stall_q(stall_q), .arm_q(arm_q),
    .dir_q(dir_q), .ev_status_ack(ev_status_ack), .resp_q(resp_q),
    .resp_vld_q(resp_vld)
  );

  assign stage      = stage_q;
  assign resp       = resp_q;
  assign dsen_rdata = 1'b0;
endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_setup,
  input logic       tok_in,
  input logic       tok_out,
  input logic       hs_done,
  input logic       fw_dsen,
  input logic [1:0] stage,
  input logic [1:0] resp,
  input logic       resp_vld,
  input logic       arm_q,
  input logic       stall_q,
  input logic       dir_q
);
  a_r2_setup_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> (stage == 2'd1 && !arm_q && !stall_q && resp == 2'd1 && resp_vld));

  a_r3_nak_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    ((tok_in || tok_out) && !tok_setup && stage == 2'd1 && !stall_q) |=> resp == 2'd2);

  a_r5_arm_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd2 && hs_done && !fw_dsen && !tok_setup) |=> !arm_q);

  a_r8_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && (tok_in || tok_out) && !tok_setup) |=> resp == 2'd3);

  a_r7_status_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd3 && !stall_q && !tok_setup &&
     ((tok_in && !dir_q) || (tok_out && !tok_in && dir_q))) |=> (resp == 2'd1 && stage == 2'd0));

  a_r10_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_setup || tok_in || tok_out) |=> resp_vld);

  a_r10_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(tok_setup || tok_in || tok_out) |=> (!resp_vld && resp == 2'd0));
endmodule

bind ctl_stage_seq ctl_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_in(tok_in),
  .tok_out(tok_out), .hs_done(hs_done), .fw_dsen(fw_dsen), .stage(stage),
  .resp(resp), .resp_vld(resp_vld), .arm_q(arm_q), .stall_q(stall_q), .dir_q(dir_q)
);

// File: tb/ctl_stage_seq_tb.sv
module ctl_stage_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_setup = 0, setup_dir_in = 0, tok_in = 0, tok_out = 0;
  logic hs_done = 0, fw_dsen = 0, fw_status = 0, fw_stall = 0;
  logic [1:0] stage, resp;
  logic resp_vld, dsen_rdata;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  int m_stage = 0;
  bit m_arm = 0, m_stall = 0, m_dir = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_stage_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .setup_dir_in(setup_dir_in),
    .tok_in(tok_in), .tok_out(tok_out), .hs_done(hs_done), .fw_dsen(fw_dsen),
    .fw_status(fw_status), .fw_stall(fw_stall), .stage(stage), .resp(resp),
    .resp_vld(resp_vld), .dsen_rdata(dsen_rdata)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ops: 0 IN, 1 OUT, 2 handshake done, 3 arm, 4 status, 5 stall, 6 SETUP
  task automatic apply_op(int op, bit dir);
    int    code = 0;
    bit    vld  = 0;
    string tag;
    case (op)
      0, 1: begin
        bit is_in = (op == 0);
        vld = 1;
        if (m_stall) begin
          code = 3; tag = "R8";
        end else begin
          case (m_stage)
            0: begin code = 2; tag = "R11"; end
            1: begin code = 2; tag = "R3"; end
            2: begin
              code = (m_arm && is_in == m_dir) ? 1 : 2;
              tag = (is_in == m_dir) ? "R4" : "R11";
            end
            default: begin
              code = (is_in != m_dir) ? 1 : 2;
              tag = "R7";
              if (code == 1) m_stage = 0;
            end
          endcase
        end
      end
      2: begin tag = "R5"; m_arm = 0; end
      3: begin tag = "R4"; m_arm = 1; if (m_stage == 1) m_stage = 2; end
      4: begin
        tag = "R6";
        if (m_stage == 1 || m_stage == 2) begin m_stage = 3; m_arm = 0; end
      end
      5: begin tag = "R8"; m_stall = 1; end
      default: begin
        tag = "R2"; vld = 1; code = 1;
        m_stage = 1; m_arm = 0; m_stall = 0; m_dir = dir;
      end
    endcase
    @(negedge clk);
    tok_in    = (op == 0);
    tok_out   = (op == 1);
    hs_done   = (op == 2);
    fw_dsen   = (op == 3);
    fw_status = (op == 4);
    fw_stall  = (op == 5);
    tok_setup = (op == 6);
    setup_dir_in = dir;
    @(negedge clk);
    {tok_in, tok_out, hs_done, fw_dsen, fw_status, fw_stall, tok_setup} = '0;
    check("R10", "resp_vld", int'(resp_vld), int'(vld));
    check(tag, "resp", int'(resp), code);
    check(tag, "stage", int'(stage), m_stage);
    check("R9", "dsen_rdata", int'(dsen_rdata), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "stage", int'(stage), 0);
    check("R1", "resp_vld", int'(resp_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "stage", int'(stage), 0);

    // R11: idle token
    apply_op(0, 0);
    // R12 directed: OUT transfer, arm, ACK, handshake, NAK (R5), re-arm, ACK
    apply_op(6, 0);
    apply_op(3, 0);
    apply_op(1, 0);
    apply_op(2, 0);
    apply_op(1, 0);
    apply_op(3, 0);
    check("R12", "armed again in data stage", int'(stage), 2);
    apply_op(1, 0);
    // R6/R7: status, same-direction NAK, opposite-direction ACK
    apply_op(4, 0);
    apply_op(1, 0);
    apply_op(0, 0);
    check("R7", "back to idle", int'(stage), 0);
    // R8: stall, then SETUP clears it (R2)
    apply_op(6, 1);
    apply_op(5, 1);
    apply_op(0, 1);
    apply_op(6, 1);
    apply_op(0, 1);

    // near-exhaustive sweep: every 3-op sequence after a SETUP, both directions
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++)
          for (int c = 0; c < 7; c++) begin
            apply_op(6, bit'(d));
            apply_op(a, bit'(d ^ 1));
            apply_op(b, bit'(d ^ 1));
            apply_op(c, bit'(d ^ 1));
            apply_op(0, bit'(d));
            apply_op(1, bit'(d));
          end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule